// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shifter

This block is the logic core of a display gate-line scan driver. A chain of 256 registered stages carries a start pulse across the gate outputs, one position per rising edge of the shift clock. The direction input selects whether the pulse runs from the lowest-numbered output to the highest or the other way. The next driver in a cascade needs a start pulse of its own. The block produces it on the pin at the far end of the scan. That pulse is registered on the falling clock edge, which gives the next stage a half cycle of setup before it samples.

There are two start pins, A and B, and both are bidirectional. In the forward direction, A is the input and B carries the cascade pulse out. In the reverse direction the roles swap. The pin acting as input is left at high impedance by the block. Three blanking inputs pull interleaved thirds of the outputs low, and an active-low all-on input drives every output high. Both overrides act combinationally on the outputs and leave the stage register untouched, so the scan position survives them. The interface has no data streams, so every pin is a plain level signal with no handshake.

Top module: `gate_scan_shifter`

## Requirements
- R1: While `rst_n` is low, every stage and the cascade output are cleared without waiting for a clock, so `gate_out` is all zero when `all_on_n` is high.
- R2: With `dir_fwd` = 1, each rising edge loads the level on `start_a` into stage 0 (`gate_out[0]`) and moves stage i into stage i+1. A pulse sampled on the first edge appears at `gate_out[k-1]` after the k-th edge.
- R3: With `dir_fwd` = 0, each rising edge loads the level on `start_b` into stage 255 and moves stage i into stage i-1. A pulse sampled on the first edge appears at `gate_out[256-k]` after the k-th edge.
- R4: The cascade output follows the terminal stage (stage 255 forward, stage 0 reverse), updated on each falling edge. It is driven on `start_b` when `dir_fwd` = 1 and on `start_a` when `dir_fwd` = 0. For a single pulse it rises on the falling edge of the 256th clock and falls on the falling edge of the 257th.
- R5: Output `gate_out[i]` belongs to blanking group i mod 3: group 0 is `blank[0]` (outputs 1, 4, ... 256 in 1-based numbering), group 1 is `blank[1]`, and group 2 is `blank[2]`. A high blanking bit forces its group low at once, with no clock edge, and leaves the other groups unaffected.
- R6: Blanking does not alter the stage register. A pulse keeps shifting while blanked and becomes visible as soon as it reaches an unblanked output.
- R7: `all_on_n` low forces every output high at once and overrides all blanking bits. The stage register keeps shifting underneath, so the scan position is correct once `all_on_n` returns high.
- R8: Several ones in the chain (overlapping start pulses) shift together without merging or loss.
- R9: Changing `dir_fwd` in the middle of a scan reverses the motion of the pulses already in the chain, and the start input switches to the other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; stages move on the rising edge, cascade output updates on the falling edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| dir_fwd | input | 1 | 1: scan from `gate_out[0]` upward; 0: scan from `gate_out[255]` downward |
| start_a | inout | 1 | Start input when forward, cascade output when reverse |
| start_b | inout | 1 | Cascade output when forward, start input when reverse |
| blank | input | 3 | Per-group blanking, bit g covers outputs with index mod 3 = g |
| all_on_n | input | 1 | Active-low force of every output high |
| gate_out | output | 256 | Gate-line levels |

## Verification
Directed single-pulse scans in both directions pin down the pulse position on every edge. They also fix the two falling edges that bound the cascade pulse and show which pin carries it. An overlapping burst of start bits separates a true shift from a chain that keeps only one marker. Blanking and all-on are applied between edges with a pulse parked in a known group, which separates the asynchronous masks from anything clocked. Scanning resumes after each override to show the register was kept. A long random run then mixes sparse start pulses, direction flips, blanking and all-on against a bench model of the chain, to catch interactions the directed cases miss.

// File: rtl/gsr_pkg.sv
`timescale 1ns/1ps
package gsr_pkg;

  typedef enum logic {
    SCAN_REV = 1'b0,
    SCAN_FWD = 1'b1
  } scan_dir_e;

  function automatic int gsr_group_of(input int idx, input int groups);
    return idx % groups;
  endfunction

endpackage

// File: rtl/gsr_shift_chain.sv
`timescale 1ns/1ps
module gsr_shift_chain #(
  parameter int STAGES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  input  logic              shift_in,
  output logic [STAGES-1:0] stage_q
);

  logic [STAGES-1:0] stage_d;

  // each stage picks its lower or upper neighbour; the ends take the start bit
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic from_low;
    logic from_high;

    if (i == 0) begin : g_lo_end
      assign from_low = shift_in;
    end else begin : g_lo_mid
      assign from_low = stage_q[i-1];
    end

    if (i == STAGES-1) begin : g_hi_end
      assign from_high = shift_in;
    end else begin : g_hi_mid
      assign from_high = stage_q[i+1];
    end

    assign stage_d[i] = dir_fwd ? from_low : from_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

endmodule

// File: rtl/gsr_cascade_port.sv
`timescale 1ns/1ps
module gsr_cascade_port (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_fwd,
  input  logic pin_a_in,
  input  logic pin_b_in,
  input  logic tail_fwd,
  input  logic tail_rev,
  output logic shift_in,
  output logic casc_q
);

  logic tail;

  assign shift_in = dir_fwd ? pin_a_in : pin_b_in;
  assign tail     = dir_fwd ? tail_fwd : tail_rev;

  // falling-edge register: half a cycle of setup for the next driver
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) casc_q <= 1'b0;
    else        casc_q <= tail;
  end

endmodule

// File: rtl/gsr_output_mask.sv
`timescale 1ns/1ps
module gsr_output_mask
  import gsr_pkg::*;
#(
  parameter int STAGES = 256,
  parameter int GROUPS = 3
) (
  input  logic [STAGES-1:0] stage_q,
  input  logic [GROUPS-1:0] blank,
  input  logic              all_on_n,
  output logic [STAGES-1:0] gate_out
);

  for (genvar i = 0; i < STAGES; i++) begin : g_out
    localparam int GRP = gsr_group_of(i, GROUPS);
    assign gate_out[i] = (stage_q[i] & ~blank[GRP]) | ~all_on_n;
  end

endmodule

// File: rtl/gate_scan_shifter.sv
`timescale 1ns/1ps
module gate_scan_shifter #(
  parameter int STAGES = 256,
  parameter int GROUPS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_fwd,
  inout  wire               start_a,
  inout  wire               start_b,
  input  logic [GROUPS-1:0] blank,
  input  logic              all_on_n,
  output logic [STAGES-1:0] gate_out
);

  logic [STAGES-1:0] stage_q;
  logic              shift_in;
  logic              casc_q;

  // the input-side pin is released, the output-side pin carries the cascade
  assign start_a = dir_fwd ? 1'bz : casc_q;
  assign start_b = dir_fwd ? casc_q : 1'bz;

  gsr_cascade_port u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_fwd  (dir_fwd),
    .pin_a_in (start_a),
    .pin_b_in (start_b),
    .tail_fwd (stage_q[STAGES-1]),
    .tail_rev (stage_q[0]),
    .shift_in (shift_in),
    .casc_q   (casc_q)
  );

  gsr_shift_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_fwd  (dir_fwd),
    .shift_in (shift_in),
    .stage_q  (stage_q)
  );

  gsr_output_mask #(.STAGES(STAGES), .GROUPS(GROUPS)) u_mask (
    .stage_q  (stage_q),
    .blank    (blank),
    .all_on_n (all_on_n),
    .gate_out (gate_out)
  );

endmodule

// File: rtl/gsr_checker.sv
`timescale 1ns/1ps
module gsr_checker #(
  parameter int STAGES = 256,
  parameter int GROUPS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_fwd,
  input logic              start_a,
  input logic              start_b,
  input logic [GROUPS-1:0] blank,
  input logic              all_on_n,
  input logic [STAGES-1:0] gate_out,
  input logic [STAGES-1:0] stage_q,
  input logic              casc_q
);

  function automatic logic [STAGES-1:0] group_mask(input int g);
    logic [STAGES-1:0] m;
    m = '0;
    for (int i = 0; i < STAGES; i++) if (i % GROUPS == g) m[i] = 1'b1;
    return m;
  endfunction

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (stage_q == '0 && !casc_q));

  assert_fwd_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fwd |=> (stage_q[STAGES-1:1] == $past(stage_q[STAGES-2:0]) &&
                 stage_q[0] == $past(start_a)));

  assert_rev_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_fwd |=> (stage_q[STAGES-2:0] == $past(stage_q[STAGES-1:1]) &&
                  stage_q[STAGES-1] == $past(start_b)));

  assert_casc_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && $stable(dir_fwd)) |-> (start_b == stage_q[STAGES-1]));

  assert_casc_rev_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_fwd && $stable(dir_fwd)) |-> (start_a == stage_q[0]));

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam logic [STAGES-1:0] GMASK = group_mask(g);
    assert_blank_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (all_on_n && blank[g]) |-> ((gate_out & GMASK) == '0));
  end

  assert_no_phantom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    all_on_n |-> ((gate_out & ~stage_q) == '0));

  assert_all_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !all_on_n |-> (&gate_out));

endmodule

bind gate_scan_shifter gsr_checker #(.STAGES(STAGES), .GROUPS(GROUPS)) u_gsr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir_fwd  (dir_fwd),
  .start_a  (start_a),
  .start_b  (start_b),
  .blank    (blank),
  .all_on_n (all_on_n),
  .gate_out (gate_out),
  .stage_q  (stage_q),
  .casc_q   (casc_q)
);

// File: tb/gate_scan_shifter_bench.sv
`timescale 1ns/1ps
module gate_scan_shifter_bench;

  localparam int N = 256;

  logic         clk = 1'b0;
  logic         rst_n = 1'b1;
  logic         t_dir = 1'b1;
  logic         t_start = 1'b0;
  logic [2:0]   t_blank = 3'b000;
  logic         t_allon_n = 1'b1;
  wire          pin_a;
  wire          pin_b;
  logic [N-1:0] gate_out;

  logic [N-1:0] ref_st = '0;
  logic         ref_casc = 1'b0;
  int           total = 0;
  int           bad = 0;
  bit           done = 0;

  assign pin_a = t_dir ? t_start : 1'bz;
  assign pin_b = t_dir ? 1'bz : t_start;

  always #2.5 clk = ~clk;

  gate_scan_shifter u_gate_scan_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_fwd  (t_dir),
    .start_a  (pin_a),
    .start_b  (pin_b),
    .blank    (t_blank),
    .all_on_n (t_allon_n),
    .gate_out (gate_out)
  );

  function automatic logic [N-1:0] next_st(input logic [N-1:0] s, input logic d, input logic b);
    return d ? {s[N-2:0], b} : {b, s[N-1:1]};
  endfunction

  function automatic logic [N-1:0] exp_gates(input logic [N-1:0] s, input logic [2:0] bl,
                                             input logic an);
    logic [N-1:0] e;
    for (int i = 0; i < N; i++) e[i] = (s[i] & ~bl[i % 3]) | ~an;
    return e;
  endfunction

  function automatic logic [N-1:0] onehot(input int k);
    logic [N-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock: model shift at the rising edge, cascade at the falling edge
  task automatic tick();
    @(posedge clk);
    ref_st = next_st(ref_st, t_dir, t_start);
    #1;
    chk_vec(t_dir ? "R2" : "R3", gate_out, exp_gates(ref_st, t_blank, t_allon_n));
    @(negedge clk);
    ref_casc = t_dir ? ref_st[N-1] : ref_st[0];
    #1;
    chk_bit("R4", t_dir ? pin_b : pin_a, ref_casc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ref_st = '0;
    ref_casc = 1'b0;
    #0.5;
    chk_vec("R1", gate_out, '0);
    @(negedge clk);
    #1;
    chk_bit("R1", t_dir ? pin_b : pin_a, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    t_allon_n = 1'b1;
    t_blank = '0;
    #0.5;
    do_reset();

    // forward single-pulse scan, cascade on pin B
    t_dir = 1'b1;
    t_start = 1'b1;
    for (int k = 1; k <= 257; k++) begin
      tick();
      t_start = 1'b0;
      chk_vec("R2", gate_out, (k <= N) ? onehot(k-1) : '0);
      chk_bit("R4", pin_b, (k == 256));
    end

    // reverse single-pulse scan, cascade on pin A
    t_dir = 1'b0;
    t_start = 1'b1;
    for (int k = 1; k <= 257; k++) begin
      tick();
      t_start = 1'b0;
      chk_vec("R3", gate_out, (k <= N) ? onehot(N-k) : '0);
      chk_bit("R4", pin_a, (k == 256));
    end

    // overlapping pulses: inputs 1,1,1,0,1,0 forward
    do_reset();
    t_dir = 1'b1;
    for (int k = 0; k < 6; k++) begin
      t_start = (k == 3 || k == 5) ? 1'b0 : 1'b1;
      tick();
    end
    t_start = 1'b0;
    chk_vec("R8", gate_out, {{(N-6){1'b0}}, 6'b111010});

    // blanking with a pulse parked at index 9 (group 0)
    do_reset();
    t_dir = 1'b1;
    t_start = 1'b1;
    tick();
    t_start = 1'b0;
    for (int k = 0; k < 9; k++) tick();
    t_blank = 3'b001;
    #0.5;
    chk_vec("R5", gate_out, '0);
    t_blank = 3'b110;
    #0.5;
    chk_vec("R5", gate_out, onehot(9));
    t_blank = 3'b001;
    tick();
    chk_vec("R6", gate_out, onehot(10));
    t_blank = 3'b000;

    // all-on overrides blanking and keeps the scan moving underneath
    t_allon_n = 1'b0;
    t_blank = 3'b111;
    #0.5;
    chk_vec("R7", gate_out, '1);
    for (int k = 0; k < 5; k++) tick();
    chk_vec("R7", gate_out, '1);
    t_allon_n = 1'b1;
    t_blank = 3'b000;
    #0.5;
    chk_vec("R7", gate_out, onehot(15));

    // direction reversal mid-scan
    t_dir = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk_vec("R9", gate_out, onehot(10));

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      t_start = ($urandom % 32) == 0;
      if (($urandom % 500) == 0) t_dir = ~t_dir;
      for (int g = 0; g < 3; g++) t_blank[g] = ($urandom % 6) == 0;
      t_allon_n = ($urandom % 25) != 0;
      tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule